// File: doc/BRIEF.md
# Posted Slow-IO Write Buffer

This block sits between a processor core and a slow, off-chip, memory-mapped peripheral bus. A range comparator picks out core accesses that fall into the uncached IO window. Every other access is forwarded unchanged, in the same cycle, to the normal memory port.

An IO write is captured in a single-entry latch that holds the address, data and direction. The core is released in the cycle it presents the write, and the latch then runs the external cycle on its own. The core is held back only if it issues another IO write while that external cycle is still open. IO reads always hold the core until the peripheral returns data. A read that arrives while a posted write is outstanding waits for the write to complete first, so the peripheral sees the accesses in program order.

The slow-bus side uses a level request with a one-cycle acknowledge. It is driven only from the internal latches, so its timing does not depend on the core-side inputs. The core must hold an access steady for as long as the stall output is high. The access is taken in the first cycle that the stall output is low.

Top module: `posted_io_wbuf`

## Requirements
- R1: After reset, the slow-bus request and the memory-port request are low, and the stall output is low while the core presents no request.
- R2: An address is an IO access when (address AND IO_MASK) equals IO_BASE (default 0xF000_0000 for both). Any other access drives the memory port in the same cycle with the core's address, write flag and write data. The stall output then follows the memory port's stall, read data comes from the memory port, and no slow-bus cycle starts.
- R3: An IO write made while no slow-bus cycle is in progress is taken without a stall. In the next cycle the slow bus requests with the write flag set and the captured address and data.
- R4: An IO write made while the slow-bus request is high is stalled in every such cycle. It is taken in the first cycle in which the request is low.
- R5: An IO read always stalls in the cycle it is first presented. The core is released in the cycle after the acknowledge, and it then receives the data that the peripheral returned with that acknowledge.
- R6: An IO read issued while a posted write is still pending is not started until that write is acknowledged. A read of a location then returns the value of the most recent IO write to it.
- R7: While the slow-bus request is high and not acknowledged, the address, data and write flag stay constant. The request drops in the cycle after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req | input | 1 | Core access valid |
| core_we | input | 1 | Core access is a write |
| core_addr | input | AW | Core byte address |
| core_wdata | input | DW | Core write data |
| core_stall | output | 1 | Hold the access; it is taken when low |
| core_rdata | output | DW | Read data for the core |
| mem_req | output | 1 | Access forwarded to the memory port |
| mem_we | output | 1 | Forwarded write flag |
| mem_addr | output | AW | Forwarded address |
| mem_wdata | output | DW | Forwarded write data |
| mem_rdata | input | DW | Memory-port read data |
| mem_stall | input | 1 | Memory-port stall |
| bus_req | output | 1 | Slow-bus request, held until acknowledged |
| bus_we | output | 1 | Slow-bus write flag |
| bus_addr | output | AW | Slow-bus address from the latch |
| bus_wdata | output | DW | Slow-bus write data from the latch |
| bus_ack | input | 1 | One-cycle slow-bus acknowledge |
| bus_rdata | input | DW | Slow-bus read data, valid with the acknowledge |

## Verification
Directed sequences separate the three write cases: a write to an idle bus, which must not stall; a write straight after another write, which must stall until the request drops; and a write with a memory-port access slipped in between, which must not be held up by the pending IO cycle. A write followed at once by a read of the same location separates correct ordering from a read that overtakes the posted write. A seeded random mix of IO reads, IO writes and memory-port accesses, run against random acknowledge latencies of zero to several cycles, checks on every cycle that the write stall matches the bus state. It also checks each read value against a shadow copy kept in program order.

// File: rtl/posted_io_wbuf_pkg.sv
package posted_io_wbuf_pkg;
   typedef enum logic [1:0] {
      PB_IDLE  = 2'd0,
      PB_WBUSY = 2'd1,
      PB_RBUSY = 2'd2,
      PB_RDONE = 2'd3
   } pb_state_t;

   localparam int MATCH_MASK   = 0;
   localparam int MATCH_BOUNDS = 1;
endpackage

// File: rtl/io_window_decode.sv
module io_window_decode #(
   parameter int AW = 32,
   parameter int MATCH_KIND = 0,
   parameter logic [AW-1:0] WIN_BASE = '0,
   parameter logic [AW-1:0] WIN_MASK = '0,
   parameter logic [AW-1:0] WIN_LO = '0,
   parameter logic [AW-1:0] WIN_HI = '0
) (
   input  logic [AW-1:0] addr,
   output logic          hit
);
   import posted_io_wbuf_pkg::*;

   generate
      if (MATCH_KIND == MATCH_MASK) begin : g_mask
         assign hit = ((addr & WIN_MASK) == WIN_BASE);
      end else if (MATCH_KIND == MATCH_BOUNDS) begin : g_bounds
         assign hit = (addr >= WIN_LO) && (addr <= WIN_HI);
      end else begin : g_bad_kind
         $error("io_window_decode: unsupported MATCH_KIND");
         assign hit = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/io_post_ctrl.sv
module io_post_ctrl #(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          io_req,
   input  logic          io_we,
   input  logic [AW-1:0] io_addr,
   input  logic [DW-1:0] io_wdata,
   output logic          io_stall,
   output logic [DW-1:0] io_rdata,
   output logic          bus_req,
   output logic          bus_we,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_wdata,
   input  logic          bus_ack,
   input  logic [DW-1:0] bus_rdata
);
   import posted_io_wbuf_pkg::*;

   pb_state_t     st_q, st_d;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] wdat_q;
   logic [DW-1:0] rdat_q;
   logic          we_q;
   logic          launch;

   assign launch = (st_q == PB_IDLE) && io_req;

   always_comb begin
      unique case (st_q)
         PB_IDLE:  io_stall = io_req && !io_we;
         PB_RDONE: io_stall = io_req && io_we;
         default:  io_stall = io_req;
      endcase
   end

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         PB_IDLE:  if (io_req) st_d = io_we ? PB_WBUSY : PB_RBUSY;
         PB_WBUSY: if (bus_ack) st_d = PB_IDLE;
         PB_RBUSY: if (bus_ack) st_d = PB_RDONE;
         PB_RDONE: st_d = PB_IDLE;
         default:  st_d = PB_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= PB_IDLE;
         addr_q <= '0;
         wdat_q <= '0;
         rdat_q <= '0;
         we_q   <= 1'b0;
      end else begin
         st_q <= st_d;
         if (launch) begin
            addr_q <= io_addr;
            wdat_q <= io_wdata;
            we_q   <= io_we;
         end
         if (st_q == PB_RBUSY && bus_ack) rdat_q <= bus_rdata;
      end
   end

   assign bus_req   = (st_q == PB_WBUSY) || (st_q == PB_RBUSY);
   assign bus_we    = we_q;
   assign bus_addr  = addr_q;
   assign bus_wdata = wdat_q;
   assign io_rdata  = rdat_q;

   assert_bus_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

   assert_bus_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_ack) |=> !bus_req);

   assert_read_waits_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && io_req && !io_we && !bus_ack) |=> (bus_req && bus_we));
endmodule

// File: rtl/posted_io_wbuf.sv
module posted_io_wbuf #(
   parameter int AW = 32,
   parameter int DW = 32,
   parameter int MATCH_KIND = 0,
   parameter logic [AW-1:0] IO_BASE = 32'hF000_0000,
   parameter logic [AW-1:0] IO_MASK = 32'hF000_0000,
   parameter logic [AW-1:0] IO_LO = 32'hF000_0000,
   parameter logic [AW-1:0] IO_HI = 32'hFFFF_FFFF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          core_req,
   input  logic          core_we,
   input  logic [AW-1:0] core_addr,
   input  logic [DW-1:0] core_wdata,
   output logic          core_stall,
   output logic [DW-1:0] core_rdata,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mem_stall,
   output logic          bus_req,
   output logic          bus_we,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_wdata,
   input  logic          bus_ack,
   input  logic [DW-1:0] bus_rdata
);
   localparam int MIN_W = 2;

   generate
      if (AW < MIN_W || DW < 1) begin : g_bad_width
         $error("posted_io_wbuf: address or data width too small");
      end
   endgenerate

   logic          io_hit;
   logic          io_sel;
   logic          io_stall;
   logic [DW-1:0] io_rdata;

   io_window_decode #(
      .AW(AW), .MATCH_KIND(MATCH_KIND),
      .WIN_BASE(IO_BASE), .WIN_MASK(IO_MASK), .WIN_LO(IO_LO), .WIN_HI(IO_HI)
   ) u_dec (
      .addr (core_addr),
      .hit  (io_hit)
   );

   assign io_sel = core_req && io_hit;

   io_post_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .io_req    (io_sel),
      .io_we     (core_we),
      .io_addr   (core_addr),
      .io_wdata  (core_wdata),
      .io_stall  (io_stall),
      .io_rdata  (io_rdata),
      .bus_req   (bus_req),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_ack   (bus_ack),
      .bus_rdata (bus_rdata)
   );

   assign mem_req    = core_req && !io_hit;
   assign mem_we     = core_we;
   assign mem_addr   = core_addr;
   assign mem_wdata  = core_wdata;
   assign core_stall = io_sel ? io_stall : (core_req && mem_stall);
   assign core_rdata = io_sel ? io_rdata : mem_rdata;

   assert_post_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (io_sel && core_we && !bus_req) |-> !core_stall);

   assert_back_to_back_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (io_sel && core_we && bus_req) |-> core_stall);

   assert_read_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (io_sel && !core_we && bus_req) |-> core_stall);

   assert_no_stray_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!io_sel && !bus_req) |=> !bus_req);

   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !core_req |-> (!core_stall && !mem_req));
endmodule

// File: tb/sim_posted_io_wbuf.sv
module sim_posted_io_wbuf;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam logic [31:0] IO_WIN = 32'hF000_0000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          core_req = 1'b0, core_we = 1'b0;
   logic [AW-1:0] core_addr = '0;
   logic [DW-1:0] core_wdata = '0;
   logic          core_stall;
   logic [DW-1:0] core_rdata;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata = '0;
   logic          mem_stall = 1'b0;
   logic          bus_req, bus_we;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata;
   logic          bus_ack = 1'b0;
   logic [DW-1:0] bus_rdata = '0;

   int checks = 0;
   int fails = 0;
   int lat_max = 3;
   int bus_cnt = 0;
   int exp_bus = 0;
   int cyc = 0;
   logic [DW-1:0] bmem [16];
   logic [DW-1:0] smem [16];

   always #(CLK_PERIOD/2) clk = ~clk;

   posted_io_wbuf u0 (.*);

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
      end
   endtask

   // slow peripheral model
   int wait_left = 0;
   always @(posedge clk) begin
      if (!rst_n) begin
         bus_ack <= 1'b0;
      end else if (bus_ack) begin
         bus_ack <= 1'b0;
         wait_left = $urandom_range(lat_max, 0);
      end else if (bus_req) begin
         if (wait_left == 0) begin
            bus_ack <= 1'b1;
            bus_cnt++;
            if (bus_we) bmem[bus_addr[5:2]] <= bus_wdata;
            else bus_rdata <= bmem[bus_addr[5:2]];
         end else begin
            wait_left--;
         end
      end
   end

   // R7 monitor, sampled mid-cycle
   logic          p_req = 1'b0, p_ack = 1'b0, p_we = 1'b0;
   logic [AW-1:0] p_addr = '0;
   logic [DW-1:0] p_wdata = '0;
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (p_req && !p_ack)
            chk(bus_req && bus_addr == p_addr && bus_we == p_we && bus_wdata == p_wdata,
                "R7 hold", {31'b0, bus_req, bus_addr}, {31'b0, 1'b1, p_addr});
         if (p_req && p_ack) chk(!bus_req, "R7 release", 64'(bus_req), 64'd0);
      end
      p_req = bus_req; p_ack = bus_ack; p_we = bus_we;
      p_addr = bus_addr; p_wdata = bus_wdata;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   task automatic io_op(input bit we, input logic [3:0] idx, input logic [DW-1:0] d, output bit saw_stall);
      int n = 0;
      bit first = 1'b1;
      logic [AW-1:0] a = IO_WIN | (AW'(idx) << 2);
      saw_stall = 1'b0;
      @(negedge clk);
      core_req = 1'b1; core_we = we; core_addr = a; core_wdata = d;
      forever begin
         #1;
         if (we) begin
            chk(core_stall == bus_req, "R4 write stall tracks bus", 64'(core_stall), 64'(bus_req));
            if (!bus_req) chk(!core_stall, "R3 posted write free", 64'(core_stall), 64'd0);
         end else if (first) begin
            chk(core_stall, "R5 read stalls first cycle", 64'(core_stall), 64'd1);
         end
         if (!core_stall) break;
         saw_stall = 1'b1;
         first = 1'b0;
         @(negedge clk);
         n++;
         if (n > 60) begin
            chk(1'b0, "R5 op timeout", 64'(n), 64'd60);
            break;
         end
      end
      if (!we) begin
         chk(core_rdata == smem[idx], "R6 read value in order", 64'(core_rdata), 64'(smem[idx]));
         chk(!bus_req, "R5 released after bus done", 64'(bus_req), 64'd0);
      end
      exp_bus++;
      @(posedge clk);
      #1;
      core_req = 1'b0;
      if (we) begin
         smem[idx] = d;
         chk(bus_req && bus_we && bus_addr == a && bus_wdata == d, "R3 bus launch",
             {bus_req, bus_we, bus_wdata[29:0], bus_addr[31:0]}, {2'b11, d[29:0], a});
      end
   endtask

   task automatic mem_op(input bit we, input logic stl);
      logic [AW-1:0] a = 32'h1000_0000 | ($urandom() & 32'h0FFF_FFFC);
      logic [DW-1:0] d = $urandom();
      logic [DW-1:0] r = $urandom();
      logic breq0;
      @(negedge clk);
      core_req = 1'b1; core_we = we; core_addr = a; core_wdata = d;
      mem_stall = stl; mem_rdata = r;
      #1;
      breq0 = bus_req;
      chk(mem_req && mem_addr == a && mem_we == we && mem_wdata == d, "R2 forward",
          {mem_req, mem_we, mem_addr[29:0], mem_wdata[31:0]}, {1'b1, we, a[29:0], d});
      chk(core_stall == stl, "R2 stall follows memory", 64'(core_stall), 64'(stl));
      chk(core_rdata == r, "R2 read data from memory", 64'(core_rdata), 64'(r));
      @(posedge clk);
      #1;
      core_req = 1'b0; mem_stall = 1'b0;
      if (!breq0) chk(!bus_req, "R2 no bus cycle", 64'(bus_req), 64'd0);
   endtask

   initial begin
      bit s;
      void'($urandom(32'd1234));
      for (int i = 0; i < 16; i++) begin
         bmem[i] = 32'h0101_0101 * i;
         smem[i] = 32'h0101_0101 * i;
      end
      repeat (3) @(negedge clk);
      chk(!bus_req && !mem_req && !core_stall, "R1 reset state",
          {bus_req, mem_req, core_stall}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!bus_req && !core_stall, "R1 after reset release", {bus_req, core_stall}, 64'd0);

      // directed: back-to-back writes
      lat_max = 3;
      io_op(1'b1, 4'd1, 32'hA1A1_0001, s);
      chk(!s, "R3 first write not stalled", 64'(s), 64'd0);
      io_op(1'b1, 4'd2, 32'hB2B2_0002, s);
      chk(s, "R4 second write stalled", 64'(s), 64'd1);
      // memory access while write pending
      io_op(1'b1, 4'd3, 32'hC3C3_0003, s);
      mem_op(1'b0, 1'b0);
      // read straight after write to same location
      io_op(1'b1, 4'd4, 32'hD4D4_0004, s);
      io_op(1'b0, 4'd4, '0, s);
      io_op(1'b0, 4'd1, '0, s);
      mem_op(1'b1, 1'b1);

      // random mix
      for (int k = 0; k < 400; k++) begin
         int sel = $urandom_range(9, 0);
         lat_max = $urandom_range(5, 0);
         if (sel < 4) io_op(1'b1, 4'($urandom()), $urandom(), s);
         else if (sel < 7) io_op(1'b0, 4'($urandom()), '0, s);
         else mem_op(1'($urandom()), 1'($urandom()));
         if ($urandom_range(3, 0) == 0) @(negedge clk);
      end

      repeat (20) @(negedge clk);
      chk(bus_cnt == exp_bus, "R6 one bus cycle per IO access", 64'(bus_cnt), 64'(exp_bus));
      chk(!bus_req, "R7 bus idle at end", 64'(bus_req), 64'd0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule